// File: doc/BRIEF.md
# Reference Clock Activity and Qualification Monitor

This block watches a set of incoming reference clocks in parallel and reports, for each one, whether it is toggling (active) and whether it may be used as a timing source (qualified). Each reference is first brought into the master-clock domain, and its rising edges are detected. A leaky bucket tracks activity. It fills while monitoring windows pass without an edge and drains while windows contain edges. Separately, the rising edges seen during a fixed gate of master-clock cycles are counted, and the count is compared with a programmed expected value.

A reference is qualified only after it has been active and inside the offset tolerance for a programmed number of consecutive gates. Losing either condition withdraws qualification at once. A small write/read register port holds the shared thresholds. The signed measured offset of every input is presented on an output bus for the selection logic that follows this block.

Top module: `ref_qual_monitor`

## Requirements
- R1: After synchronous active-low reset, every active and qualified flag is 0, every offset is 0, and the register port returns the defaults: step-up 4, step-down 1, high mark 12, low mark 2, expected count 0, tolerance 0, soak 3. Each bucket starts at its maximum value.
- R2: Each reference passes through two flip-flops before edge detection. Only a 0-to-1 transition of the synchronized signal counts as an edge, so a reference held steadily high or steadily low produces no edges.
- R3: At the end of each window of WIN_CYCLES master cycles, a reference that produced no edge in that window has the step-up value added to its bucket. The bucket saturates at 2^BKT_W-1.
- R4: At the end of each window, a reference that produced at least one edge has the step-down value subtracted from its bucket. The bucket never goes below 0.
- R5: At a window end, the active flag is cleared when the new bucket value is greater than or equal to the high mark. It is set when the new value is less than or equal to the low mark. It holds its state for values between the two marks.
- R6: At the end of each gate of GATE_CYCLES master cycles, the offset output becomes the number of edges counted in that gate minus the expected count, as a signed CNT_W+1 bit value. Between gate ends it does not change.
- R7: A reference is in range at a gate end when the absolute value of its new offset is less than or equal to the tolerance.
- R8: While a reference is active and in range, each gate end advances its soak count. The qualified flag rises on the gate end at which the count reaches the soak setting; a setting of 0 behaves like 1.
- R9: In any cycle in which a reference is not active or not in range, its qualified flag is cleared and its soak count returns to 0 on the next clock edge.
- R10: Register addresses are 0 step-up, 1 step-down, 2 high mark, 3 low mark, 4 expected count, 5 tolerance, and 6 soak. A write takes effect on the next clock edge. Reads are combinational from the address, with the value zero-extended. Address 7 reads 0, and writes to it have no effect.
- R11: References are monitored independently; the state of one input never changes the flags or offset of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | NUM_REFS | Asynchronous reference clocks |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for reads and writes |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for cfg_addr |
| active_o | output | NUM_REFS | Per-reference activity flag |
| qual_o | output | NUM_REFS | Per-reference qualified flag |
| offset_o | output | NUM_REFS*(CNT_W+1) | Per-reference signed offset, reference i in bits [i*(CNT_W+1) +: CNT_W+1] |

## Verification
The bench starts from the full bucket after reset, so a design that reset the bucket to zero would report a silent input as active immediately. The bench stops a qualified reference and later restarts it. A design without hysteresis, or one that let the bucket wrap below zero or above its ceiling, would then toggle the active flag at the wrong window. The bench moves the expected count and the tolerance while references run, which catches a design that compares the offset off by one or with the wrong sign, or that forgets to restart the soak count. It also holds one input steadily high, to catch edge detection that counts levels instead of rising transitions, and it drives soak 0 and the unmapped address.

// File: rtl/ref_mon_pkg.sv
// Shared register addresses and reset defaults for the reference monitor.
// Assumes a 3-bit register address space.
package ref_mon_pkg;
    localparam int CFG_ADDR_W = 3;

    typedef enum logic [CFG_ADDR_W-1:0] {
        RA_STEP_UP   = 3'd0,
        RA_STEP_DOWN = 3'd1,
        RA_HIGH_MARK = 3'd2,
        RA_LOW_MARK  = 3'd3,
        RA_EXPECT    = 3'd4,
        RA_TOLERANCE = 3'd5,
        RA_SOAK      = 3'd6
    } cfg_addr_e;

    localparam int DEF_STEP_UP   = 4;
    localparam int DEF_STEP_DOWN = 1;
    localparam int DEF_HIGH_MARK = 12;
    localparam int DEF_LOW_MARK  = 2;
    localparam int DEF_EXPECT    = 0;
    localparam int DEF_TOLERANCE = 0;
    localparam int DEF_SOAK      = 3;
endpackage

// File: rtl/ref_edge_sync.sv
// Brings one asynchronous reference into the clk domain through two flops,
// then flags a rising edge of the synchronized level for one cycle.
// Assumes the reference is slower than half the master clock.
module ref_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    // Two-stage synchronizer plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= ref_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/ref_activity.sv
// Leaky-bucket activity tracker for one reference. The bucket fills by
// step_up when a window passes without an edge, and drains by step_down
// otherwise. The active flag uses high and low marks for hysteresis.
// Assumes win_end_i pulses for one cycle at the end of every window.
module ref_activity #(
    parameter int BKT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             win_end_i,
    input  logic [BKT_W-1:0] step_up,
    input  logic [BKT_W-1:0] step_down,
    input  logic [BKT_W-1:0] high_mark,
    input  logic [BKT_W-1:0] low_mark,
    output logic             active_o
);
    localparam logic [BKT_W-1:0] BKT_MAX = {BKT_W{1'b1}};

    logic [BKT_W-1:0] level_q, level_nxt;
    logic             seen_q, hit;
    logic [BKT_W:0]   fill_sum;

    // Next bucket value for the window that is closing now.
    always_comb begin
        hit      = seen_q | rise_i;
        fill_sum = {1'b0, level_q} + {1'b0, step_up};
        if (hit)
            level_nxt = (level_q > step_down) ? level_q - step_down : '0;
        else
            level_nxt = fill_sum[BKT_W] ? BKT_MAX : fill_sum[BKT_W-1:0];
    end

    // Edge memory per window, bucket update and hysteresis flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            level_q  <= BKT_MAX;
            active_o <= 1'b0;
        end else if (win_end_i) begin
            seen_q  <= 1'b0;
            level_q <= level_nxt;
            if (level_nxt >= high_mark)
                active_o <= 1'b0;
            else if (level_nxt <= low_mark)
                active_o <= 1'b1;
        end else begin
            seen_q <= hit;
        end
    end
endmodule

// File: rtl/ref_freq_meter.sv
// Counts rising edges of one reference over each gate. At the gate end,
// it publishes the signed difference from the expected count and whether
// the magnitude lies within the tolerance.
// Assumes at most GATE/2 edges per gate, so the count cannot overflow.
module ref_freq_meter #(
    parameter int CNT_W = 11,
    localparam int OFS_W = CNT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rise_i,
    input  logic                    gate_end_i,
    input  logic [CNT_W-1:0]        expect_cnt,
    input  logic [CNT_W-1:0]        tolerance,
    output logic signed [OFS_W-1:0] offset_o,
    output logic                    in_range_o
);
    logic [CNT_W-1:0]        edges_q, edges_nxt;
    logic signed [OFS_W-1:0] diff, magnitude;

    // Offset of the gate that is closing now, and its absolute value.
    always_comb begin
        edges_nxt = edges_q + CNT_W'(rise_i);
        diff      = $signed({1'b0, edges_nxt}) - $signed({1'b0, expect_cnt});
        magnitude = diff[OFS_W-1] ? -diff : diff;
    end

    // Edge counting inside the gate; results latched at the gate end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q    <= '0;
            offset_o   <= '0;
            in_range_o <= 1'b0;
        end else if (gate_end_i) begin
            edges_q    <= '0;
            offset_o   <= diff;
            in_range_o <= (magnitude <= $signed({1'b0, tolerance}));
        end else begin
            edges_q <= edges_nxt;
        end
    end
endmodule

// File: rtl/ref_soak.sv
// Soak timer for one reference: counts consecutive gate ends with the
// reference active and in range, and raises the qualified flag once the
// count reaches the soak setting. Any lapse clears it at once.
// Assumes soak_len of 0 is treated like 1.
module ref_soak #(
    parameter int SOAK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              in_range_i,
    input  logic              gate_end_i,
    input  logic [SOAK_W-1:0] soak_len,
    output logic              qual_o
);
    logic [SOAK_W-1:0] soak_q;
    logic [SOAK_W:0]   soak_inc;

    assign soak_inc = {1'b0, soak_q} + 1'b1;

    // Restart on any lapse; otherwise advance once per gate until qualified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soak_q <= '0;
            qual_o <= 1'b0;
        end else if (!(active_i && in_range_i)) begin
            soak_q <= '0;
            qual_o <= 1'b0;
        end else if (gate_end_i && !qual_o) begin
            soak_q <= soak_inc[SOAK_W-1:0];
            qual_o <= (soak_inc >= {1'b0, soak_len});
        end
    end
endmodule

// File: rtl/ref_qual_monitor.sv
// Top of the reference monitor: holds the shared configuration registers,
// runs the common window and gate timers, and builds one monitoring lane
// per reference input. Assumes DATA_W covers the widest register.
module ref_qual_monitor
    import ref_mon_pkg::*;
#(
    parameter int NUM_REFS    = 12,
    parameter int WIN_CYCLES  = 64,
    parameter int GATE_CYCLES = 1024,
    parameter int BKT_W       = 8,
    parameter int SOAK_W      = 8,
    parameter int DATA_W      = 16,
    localparam int CNT_W      = $clog2(GATE_CYCLES + 1),
    localparam int OFS_W      = CNT_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REFS-1:0]       ref_in,
    input  logic                      cfg_wr_en,
    input  logic [CFG_ADDR_W-1:0]     cfg_addr,
    input  logic [DATA_W-1:0]         cfg_wdata,
    output logic [DATA_W-1:0]         cfg_rdata,
    output logic [NUM_REFS-1:0]       active_o,
    output logic [NUM_REFS-1:0]       qual_o,
    output logic [NUM_REFS*OFS_W-1:0] offset_o
);
    localparam int WIN_W  = $clog2(WIN_CYCLES);
    localparam int GATE_W = $clog2(GATE_CYCLES);

    logic [BKT_W-1:0]  step_up_q, step_down_q, high_mark_q, low_mark_q;
    logic [CNT_W-1:0]  expect_q, tolerance_q;
    logic [SOAK_W-1:0] soak_q;
    logic [WIN_W-1:0]  win_cnt;
    logic [GATE_W-1:0] gate_cnt;
    logic              win_end, gate_end;

    // Configuration registers, written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_up_q   <= BKT_W'(DEF_STEP_UP);
            step_down_q <= BKT_W'(DEF_STEP_DOWN);
            high_mark_q <= BKT_W'(DEF_HIGH_MARK);
            low_mark_q  <= BKT_W'(DEF_LOW_MARK);
            expect_q    <= CNT_W'(DEF_EXPECT);
            tolerance_q <= CNT_W'(DEF_TOLERANCE);
            soak_q      <= SOAK_W'(DEF_SOAK);
        end else if (cfg_wr_en) begin
            case (cfg_addr)
                RA_STEP_UP:   step_up_q   <= cfg_wdata[BKT_W-1:0];
                RA_STEP_DOWN: step_down_q <= cfg_wdata[BKT_W-1:0];
                RA_HIGH_MARK: high_mark_q <= cfg_wdata[BKT_W-1:0];
                RA_LOW_MARK:  low_mark_q  <= cfg_wdata[BKT_W-1:0];
                RA_EXPECT:    expect_q    <= cfg_wdata[CNT_W-1:0];
                RA_TOLERANCE: tolerance_q <= cfg_wdata[CNT_W-1:0];
                RA_SOAK:      soak_q      <= cfg_wdata[SOAK_W-1:0];
                default:      ;
            endcase
        end
    end

    // Combinational read-back, zero-extended; unmapped address reads 0.
    always_comb begin
        case (cfg_addr)
            RA_STEP_UP:   cfg_rdata = DATA_W'(step_up_q);
            RA_STEP_DOWN: cfg_rdata = DATA_W'(step_down_q);
            RA_HIGH_MARK: cfg_rdata = DATA_W'(high_mark_q);
            RA_LOW_MARK:  cfg_rdata = DATA_W'(low_mark_q);
            RA_EXPECT:    cfg_rdata = DATA_W'(expect_q);
            RA_TOLERANCE: cfg_rdata = DATA_W'(tolerance_q);
            RA_SOAK:      cfg_rdata = DATA_W'(soak_q);
            default:      cfg_rdata = '0;
        endcase
    end

    assign win_end  = (win_cnt == WIN_W'(WIN_CYCLES - 1));
    assign gate_end = (gate_cnt == GATE_W'(GATE_CYCLES - 1));

    // Shared free-running window and gate timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            gate_cnt <= '0;
        end else begin
            win_cnt  <= win_end ? '0 : win_cnt + 1'b1;
            gate_cnt <= gate_end ? '0 : gate_cnt + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_REFS; i++) begin : g_lane
        logic                    rise, in_range;
        logic signed [OFS_W-1:0] offset;

        ref_edge_sync u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_i  (ref_in[i]),
            .rise_o (rise)
        );

        ref_activity #(.BKT_W(BKT_W)) u_act (
            .clk       (clk),
            .rst_n     (rst_n),
            .rise_i    (rise),
            .win_end_i (win_end),
            .step_up   (step_up_q),
            .step_down (step_down_q),
            .high_mark (high_mark_q),
            .low_mark  (low_mark_q),
            .active_o  (active_o[i])
        );

        ref_freq_meter #(.CNT_W(CNT_W)) u_meter (
            .clk        (clk),
            .rst_n      (rst_n),
            .rise_i     (rise),
            .gate_end_i (gate_end),
            .expect_cnt (expect_q),
            .tolerance  (tolerance_q),
            .offset_o   (offset),
            .in_range_o (in_range)
        );

        ref_soak #(.SOAK_W(SOAK_W)) u_soak (
            .clk        (clk),
            .rst_n      (rst_n),
            .active_i   (active_o[i]),
            .in_range_i (in_range),
            .gate_end_i (gate_end),
            .soak_len   (soak_q),
            .qual_o     (qual_o[i])
        );

        assign offset_o[i*OFS_W +: OFS_W] = offset;
    end
endmodule

// File: rtl/ref_qual_monitor_chk.sv
// Protocol checker for the reference monitor, bound to every instance of
// the top. Relates the per-input flags and offsets to the shared timers.
module ref_qual_monitor_chk #(
    parameter int N      = 12,
    parameter int OFS_W  = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      active_o,
    input logic [N-1:0]      qual_o,
    input logic [N*OFS_W-1:0] offset_o,
    input logic              win_end,
    input logic              gate_end,
    input logic [2:0]        cfg_addr,
    input logic [DATA_W-1:0] cfg_rdata
);
    // R10: the unmapped address always reads zero.
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 3'd7) |-> (cfg_rdata == '0));

    // R6: offsets only move on the edge after a gate end.
    p_offset_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end |=> $stable(offset_o));

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R5: the activity flag only changes after a window end.
        p_active_on_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !win_end |=> $stable(active_o[i]));

        // R9: an inactive input loses qualification on the next edge.
        p_drop_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !active_o[i] |=> !qual_o[i]);

        // R8: qualification is only granted on a gate end.
        p_qual_on_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!qual_o[i] && !gate_end) |=> !qual_o[i]);
    end
endmodule

bind ref_qual_monitor ref_qual_monitor_chk #(
    .N      (NUM_REFS),
    .OFS_W  (OFS_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_o  (active_o),
    .qual_o    (qual_o),
    .offset_o  (offset_o),
    .win_end   (win_end),
    .gate_end  (gate_end),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata)
);

// File: tb/ref_qual_monitor_tb_top.sv
// Bench: behavioural model updated on every rising clock, compared with the
// design on every falling clock, plus scenario checks at chosen points.
module ref_qual_monitor_tb_top;
    localparam int N     = 4;
    localparam int WIN   = 16;
    localparam int GATE  = 64;
    localparam int CNT_W = $clog2(GATE + 1);
    localparam int OFS_W = CNT_W + 1;
    localparam int BMAX  = 255;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [N-1:0]           ref_in = '0;
    logic                   cfg_wr_en = 1'b0;
    logic [2:0]             cfg_addr = '0;
    logic [15:0]            cfg_wdata = '0;
    logic [15:0]            cfg_rdata;
    logic [N-1:0]           active_o, qual_o;
    logic [N*OFS_W-1:0]     offset_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    ref_qual_monitor #(
        .NUM_REFS(N), .WIN_CYCLES(WIN), .GATE_CYCLES(GATE),
        .BKT_W(8), .SOAK_W(8), .DATA_W(16)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .active_o(active_o), .qual_o(qual_o),
        .offset_o(offset_o)
    );

    // Reference stimulus: half period in master cycles, 0 holds the level.
    int half[N];
    int tick[N];
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (half[i] > 0) begin
                tick[i]++;
                if (tick[i] >= half[i]) begin
                    tick[i] = 0;
                    ref_in[i] = ~ref_in[i];
                end
            end
        end
    end

    // Behavioural model state.
    int m_s1[N], m_s2[N], m_s3[N], m_seen[N], m_bkt[N], m_act[N];
    int m_cnt[N], m_off[N], m_inr[N], m_sc[N], m_q[N];
    int m_wc, m_gc;
    int c_up, c_dn, c_hi, c_lo, c_exp, c_tol, c_soak;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wc = 0; m_gc = 0;
            c_up = 4; c_dn = 1; c_hi = 12; c_lo = 2; c_exp = 0; c_tol = 0; c_soak = 3;
            for (int i = 0; i < N; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_seen[i] = 0;
                m_bkt[i] = BMAX; m_act[i] = 0; m_cnt[i] = 0; m_off[i] = 0;
                m_inr[i] = 0; m_sc[i] = 0; m_q[i] = 0;
            end
        end else begin
            bit we, ge;
            we = (m_wc == WIN - 1);
            ge = (m_gc == GATE - 1);
            for (int i = 0; i < N; i++) begin
                int e, nb, mag;
                e = (m_s2[i] != 0 && m_s3[i] == 0) ? 1 : 0;
                if (!(m_act[i] != 0 && m_inr[i] != 0)) begin
                    m_sc[i] = 0; m_q[i] = 0;
                end else if (ge && m_q[i] == 0) begin
                    m_sc[i]++;
                    if (m_sc[i] >= c_soak) m_q[i] = 1;
                end
                if (we) begin
                    if (m_seen[i] != 0 || e != 0) nb = (m_bkt[i] > c_dn) ? m_bkt[i] - c_dn : 0;
                    else nb = (m_bkt[i] + c_up > BMAX) ? BMAX : m_bkt[i] + c_up;
                    m_bkt[i] = nb;
                    if (nb >= c_hi) m_act[i] = 0;
                    else if (nb <= c_lo) m_act[i] = 1;
                    m_seen[i] = 0;
                end else begin
                    m_seen[i] = m_seen[i] | e;
                end
                if (ge) begin
                    m_off[i] = m_cnt[i] + e - c_exp;
                    mag = (m_off[i] < 0) ? -m_off[i] : m_off[i];
                    m_inr[i] = (mag <= c_tol) ? 1 : 0;
                    m_cnt[i] = 0;
                end else begin
                    m_cnt[i] += e;
                end
                m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = int'(ref_in[i]);
            end
            m_wc = we ? 0 : m_wc + 1;
            m_gc = ge ? 0 : m_gc + 1;
            if (cfg_wr_en) begin
                case (cfg_addr)
                    3'd0: c_up   = int'(cfg_wdata[7:0]);
                    3'd1: c_dn   = int'(cfg_wdata[7:0]);
                    3'd2: c_hi   = int'(cfg_wdata[7:0]);
                    3'd3: c_lo   = int'(cfg_wdata[7:0]);
                    3'd4: c_exp  = int'(cfg_wdata[CNT_W-1:0]);
                    3'd5: c_tol  = int'(cfg_wdata[CNT_W-1:0]);
                    3'd6: c_soak = int'(cfg_wdata[7:0]);
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d (phase %s) t=%0t", req, what, got, exp, phase, $time);
        end
    endtask

    function automatic int dut_off(input int i);
        logic signed [OFS_W-1:0] v;
        v = offset_o[i*OFS_W +: OFS_W];
        return int'(v);
    endfunction

    // Cycle compare: R5 active, R8/R9 qualified, R6/R7 offset, every lane (R11).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < N; i++) begin
                check("R5", $sformatf("ref%0d active", i), int'(active_o[i]), m_act[i]);
                check("R8", $sformatf("ref%0d qual", i), int'(qual_o[i]), m_q[i]);
                check("R6", $sformatf("ref%0d offset", i), dut_off(i), m_off[i]);
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input int exp);
        @(negedge clk);
        cfg_addr = 3'(a);
        #1;
        check(req, $sformatf("reg%0d", a), int'(cfg_rdata), exp);
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        half[0] = 4; half[1] = 5; half[2] = 0; half[3] = 2;
        for (int i = 0; i < N; i++) tick[i] = 0;
        run(5);
        // R1: reset state and register defaults.
        for (int i = 0; i < N; i++) begin
            check("R1", "reset active", int'(active_o[i]), 0);
            check("R1", "reset qual", int'(qual_o[i]), 0);
            check("R1", "reset offset", dut_off(i), 0);
        end
        rd_check("R1", 0, 4); rd_check("R1", 1, 1); rd_check("R1", 2, 12);
        rd_check("R1", 3, 2); rd_check("R1", 4, 0); rd_check("R1", 5, 0);
        rd_check("R1", 6, 3);
        @(negedge clk); rst_n = 1'b1;

        // R10: programming, read-back and the unmapped address.
        phase = "R10";
        wr(1, 2); wr(4, 8); wr(5, 1);
        rd_check("R10", 1, 2); rd_check("R10", 4, 8); rd_check("R10", 5, 1);
        wr(7, 16'hFFFF);
        rd_check("R10", 7, 0); rd_check("R10", 0, 4); rd_check("R10", 6, 3);

        // R3/R4/R7/R8: full bucket drains, ref0 soaks in; ref3 stays out of range.
        phase = "R8";
        run(3000);
        check("R4", "ref0 active after draining", int'(active_o[0]), 1);
        check("R8", "ref0 qualified", int'(qual_o[0]), 1);
        check("R3", "ref2 silent stays inactive", int'(active_o[2]), 0);
        check("R6", "ref3 offset +8", dut_off(3), 8);
        check("R7", "ref3 out of range", int'(qual_o[3]), 0);

        // R11/R7: move expected count and tolerance; both fast and slow lanes judged alone.
        phase = "R11";
        wr(4, 12); wr(5, 4);
        run(700);
        check("R11", "ref3 qualified", int'(qual_o[3]), 1);
        check("R7", "ref0 at tolerance edge", int'(qual_o[0]), 1);
        check("R6", "ref0 offset -4", dut_off(0), -4);

        // R9/R5: stop ref0, it goes inactive and loses qualification.
        phase = "R9";
        half[0] = 0;
        run(200);
        check("R9", "ref0 qual dropped", int'(qual_o[0]), 0);
        check("R5", "ref0 inactive", int'(active_o[0]), 0);
        check("R11", "ref3 unaffected", int'(qual_o[3]), 1);

        // R5: restart, hysteresis drain back down to the low mark.
        phase = "R5";
        half[0] = 4;
        run(120);
        check("R5", "ref0 still inactive mid-drain", int'(active_o[0]), 0);
        run(600);
        check("R5", "ref0 active again", int'(active_o[0]), 1);

        // R8: soak setting 0 behaves as 1.
        phase = "R8";
        wr(6, 0);
        half[3] = 0;
        run(200);
        half[3] = 2;
        run(700);
        check("R8", "ref3 requalified with soak 0", int'(qual_o[3]), 1);

        // R2: a level held high gives no edges.
        phase = "R2";
        half[2] = 0; ref_in[2] = 1'b1;
        run(500);
        check("R2", "ref2 held high inactive", int'(active_o[2]), 0);
        check("R2", "ref2 held high offset", dut_off(2), -12);

        finish_run();
    end
endmodule